// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Function Select

This block owns the pads of a bank of general-purpose pins (54 by default). A 3-bit function code per pin picks who drives the pad. The pin can be a plain input with its driver off. It can be a GPIO output driven from an internal output latch. Or it can be handed to one of six alternate-function ports, which then supply both the output value and the output enable.

Software reaches the block through a single 32-bit register port. It programs function codes ten pins to a word and pull settings sixteen pins to a word. The output latch is changed only through write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. The pad input levels are read back through a two-flop synchroniser. A 2-bit pull setting per pin leaves the block on `pad_pull` for the pad ring to apply.

Top module: `gpio_fsel_ctrl`

## Requirements
- R1: After a synchronous reset, every function code is 000, the output latch is all zero, every pull field is 00, `pad_oe`, `pad_out` and `pad_pull` are all zero, and `bus_rdata` is zero.
- R2: A pin whose function code is 000 has its output enable low and its pad output low.
- R3: A pin whose function code is 001 has its output enable high and its pad output equal to its latch bit.
- R4: Codes 100, 101, 110 and 111 route alternate port 0, 1, 2 and 3 to the pad, code 011 routes port 4, and code 010 routes port 5. The routed port supplies both the pad output and the output enable. Alternate port a for pin p sits at bit a*NPINS+p of `alt_out` and `alt_oe`.
- R5: The function words are at byte offsets 0x00, 0x04, … 0x14. Pin p lives in word p/10, at bits 3*(p%10)+2 down to 3*(p%10). Reads return the stored codes. Bits 31:30 and the fields of pins at or above NPINS read 0 and cannot be written.
- R6: A write to 0x1C sets the latch of pin b for every 1 in data bit b. A write to 0x20 does the same for pin 32+b. Zero bits leave the latch alone, and both words read as 0.
- R7: Offsets 0x28 and 0x2C clear latch bits with the same pin mapping, and zero bits have no effect. Only one bus access happens per cycle, so when a pin is both set and cleared, the access that comes later wins.
- R8: Offsets 0x34 (pins 0–31) and 0x38 (pins 32 and up) return the pad inputs after a two-flop synchroniser. A read issued two cycles after an input change shows the new level, and a read issued one cycle after still shows the old level. Writes to these words are ignored.
- R9: The pull words are at 0xE4, 0xE8, 0xEC and 0xF0. Pin 16k+j uses bits 2j+1:2j of word k, and its setting appears on `pad_pull[2p+1:2p]` with 00 meaning none, 01 pull-up, 10 pull-down, and 11 reserved and passed through unchanged. Fields of pins at or above NPINS read 0.
- R10: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read. A read of an unmapped or unaligned offset returns 0, and a write to one changes nothing.
- R11: The latch changes only on set or clear writes. It keeps its value while the pin is in input or alternate mode and drives the pad again when the pin returns to code 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request, one per cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NPINS | Raw pad input levels |
| alt_out | input | 6*NPINS | Alternate-function output values, port-major |
| alt_oe | input | 6*NPINS | Alternate-function output enables, port-major |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_pull | output | 2*NPINS | Pull setting per pin |

## Verification
The bound checker holds on every cycle, for every pin, the input, output and alternate routing rules for the codes it covers. It also checks that the latch moves only on bus writes, the set and clear arithmetic on the low bank, the pull write-through, and zero data from unmapped offsets. The rest can only be shown by the bench's scenarios. These are the non-monotonic code table across all six alternate ports, the later-access-wins ordering of set and clear, latch retention across mode changes, and the exact two-cycle synchroniser latency of the level words. The bench also covers the zero fields above the last pin and the random mix of writes checked against its own register model.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;

    localparam int REG_W         = 32;
    localparam int ADDR_W        = 8;
    localparam int FS_W          = 3;
    localparam int PINS_PER_FS   = 10;
    localparam int PULL_W        = 2;
    localparam int PINS_PER_PULL = 16;
    localparam int NUM_ALT       = 6;
    localparam int ALT_IDX_W     = 3;

    // word indices (byte offset / 4)
    localparam int W_SET  = 7;   // 0x1C
    localparam int W_CLR  = 10;  // 0x28
    localparam int W_LEV  = 13;  // 0x34
    localparam int W_PULL = 57;  // 0xE4

    typedef enum logic [2:0] {
        FN_INPUT  = 3'b000,
        FN_OUTPUT = 3'b001,
        FN_ALT5   = 3'b010,
        FN_ALT4   = 3'b011,
        FN_ALT0   = 3'b100,
        FN_ALT1   = 3'b101,
        FN_ALT2   = 3'b110,
        FN_ALT3   = 3'b111
    } fn_code_e;

    typedef enum logic [2:0] {
        RK_NONE, RK_FSEL, RK_SET, RK_CLR, RK_LEVEL, RK_PULL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e      kind;
        logic [2:0]     idx;
    } reg_sel_t;

    typedef struct packed {
        logic                 drive;
        logic                 use_alt;
        logic [ALT_IDX_W-1:0] alt_idx;
    } pin_route_t;

    function automatic pin_route_t decode_fn(logic [FS_W-1:0] code);
        pin_route_t r;
        r.drive   = 1'b0;
        r.use_alt = 1'b0;
        r.alt_idx = '0;
        case (fn_code_e'(code))
            FN_INPUT:  r.drive = 1'b0;
            FN_OUTPUT: r.drive = 1'b1;
            default: begin
                r.use_alt = 1'b1;
                if (code[2])      r.alt_idx = {1'b0, code[1:0]};
                else if (code[0]) r.alt_idx = 3'd4;
                else              r.alt_idx = 3'd5;
            end
        endcase
        return r;
    endfunction

    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a, int n_fsel,
                                             int n_bank, int n_pull);
        reg_sel_t s;
        int       w;
        s.kind = RK_NONE;
        s.idx  = '0;
        w      = int'(a[ADDR_W-1:2]);
        if (a[1:0] == 2'b00) begin
            if (w < n_fsel) begin
                s.kind = RK_FSEL;  s.idx = 3'(w);
            end else if (w >= W_SET && w < W_SET + n_bank) begin
                s.kind = RK_SET;   s.idx = 3'(w - W_SET);
            end else if (w >= W_CLR && w < W_CLR + n_bank) begin
                s.kind = RK_CLR;   s.idx = 3'(w - W_CLR);
            end else if (w >= W_LEV && w < W_LEV + n_bank) begin
                s.kind = RK_LEVEL; s.idx = 3'(w - W_LEV);
            end else if (w >= W_PULL && w < W_PULL + n_pull) begin
                s.kind = RK_PULL;  s.idx = 3'(w - W_PULL);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 54
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            d_sync <= '0;
        end else begin
            meta_q <= d_in;
            d_sync <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_fsel_pkg::*;
#(
    parameter int NPINS = 54
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [REG_W-1:0]             bus_wdata,
    input  logic [NPINS-1:0]             level_in,
    output logic [REG_W-1:0]             bus_rdata,
    output logic [NPINS-1:0][FS_W-1:0]   fsel_q,
    output logic [NPINS-1:0]             latch_q,
    output logic [NPINS-1:0][PULL_W-1:0] pull_q
);
    localparam int N_FSEL = (NPINS + PINS_PER_FS - 1) / PINS_PER_FS;
    localparam int N_BANK = (NPINS + REG_W - 1) / REG_W;
    localparam int N_PULL = (NPINS + PINS_PER_PULL - 1) / PINS_PER_PULL;

    reg_sel_t                     sel;
    logic                         wr_hit;
    logic                         rd_hit;
    logic [NPINS-1:0][FS_W-1:0]   fsel_d;
    logic [NPINS-1:0]             latch_d;
    logic [NPINS-1:0][PULL_W-1:0] pull_d;
    logic [REG_W-1:0]             rd_word;

    assign sel    = decode_addr(bus_addr, N_FSEL, N_BANK, N_PULL);
    assign wr_hit = bus_valid & bus_write;
    assign rd_hit = bus_valid & ~bus_write;

    // next-state for every pin field
    always_comb begin
        fsel_d  = fsel_q;
        latch_d = latch_q;
        pull_d  = pull_q;
        if (wr_hit) begin
            for (int p = 0; p < NPINS; p++) begin
                if (sel.kind == RK_FSEL && int'(sel.idx) == p / PINS_PER_FS)
                    fsel_d[p] = bus_wdata[FS_W*(p % PINS_PER_FS) +: FS_W];
                if (sel.kind == RK_SET && int'(sel.idx) == p / REG_W && bus_wdata[p % REG_W])
                    latch_d[p] = 1'b1;
                if (sel.kind == RK_CLR && int'(sel.idx) == p / REG_W && bus_wdata[p % REG_W])
                    latch_d[p] = 1'b0;
                if (sel.kind == RK_PULL && int'(sel.idx) == p / PINS_PER_PULL)
                    pull_d[p] = bus_wdata[PULL_W*(p % PINS_PER_PULL) +: PULL_W];
            end
        end
    end

    // read word assembly
    always_comb begin
        rd_word = '0;
        case (sel.kind)
            RK_FSEL: begin
                for (int j = 0; j < PINS_PER_FS; j++)
                    if (int'(sel.idx) * PINS_PER_FS + j < NPINS)
                        rd_word[FS_W*j +: FS_W] = fsel_q[int'(sel.idx) * PINS_PER_FS + j];
            end
            RK_LEVEL: begin
                for (int b = 0; b < REG_W; b++)
                    if (int'(sel.idx) * REG_W + b < NPINS)
                        rd_word[b] = level_in[int'(sel.idx) * REG_W + b];
            end
            RK_PULL: begin
                for (int j = 0; j < PINS_PER_PULL; j++)
                    if (int'(sel.idx) * PINS_PER_PULL + j < NPINS)
                        rd_word[PULL_W*j +: PULL_W] = pull_q[int'(sel.idx) * PINS_PER_PULL + j];
            end
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel_q    <= '0;
            latch_q   <= '0;
            pull_q    <= '0;
            bus_rdata <= '0;
        end else begin
            fsel_q  <= fsel_d;
            latch_q <= latch_d;
            pull_q  <= pull_d;
            if (rd_hit)
                bus_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_fsel_pkg::*;
#(
    parameter int NPINS = 54
) (
    input  logic [NPINS-1:0][FS_W-1:0] fsel,
    input  logic [NPINS-1:0]           latch,
    input  logic [NUM_ALT*NPINS-1:0]   alt_out,
    input  logic [NUM_ALT*NPINS-1:0]   alt_oe,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_oe
);
    localparam int SEL_SPAN = 1 << ALT_IDX_W;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_route_t          route;
        logic [SEL_SPAN-1:0] cand_out;
        logic [SEL_SPAN-1:0] cand_oe;

        assign route = decode_fn(fsel[p]);

        for (genvar a = 0; a < SEL_SPAN; a++) begin : g_cand
            if (a < NUM_ALT) begin : g_used
                assign cand_out[a] = alt_out[a*NPINS + p];
                assign cand_oe[a]  = alt_oe[a*NPINS + p];
            end else begin : g_pad
                assign cand_out[a] = 1'b0;
                assign cand_oe[a]  = 1'b0;
            end
        end

        always_comb begin
            if (route.use_alt) begin
                pad_out[p] = cand_out[route.alt_idx];
                pad_oe[p]  = cand_oe[route.alt_idx];
            end else begin
                pad_out[p] = route.drive & latch[p];
                pad_oe[p]  = route.drive;
            end
        end
    end
endmodule

// File: rtl/gpio_fsel_ctrl.sv
module gpio_fsel_ctrl
    import gpio_fsel_pkg::*;
#(
    parameter int NPINS = 54
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    input  logic [NPINS-1:0]           pad_in,
    input  logic [NUM_ALT*NPINS-1:0]   alt_out,
    input  logic [NUM_ALT*NPINS-1:0]   alt_oe,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_oe,
    output logic [PULL_W*NPINS-1:0]    pad_pull
);
    logic [NPINS-1:0]             level_sync;
    logic [NPINS-1:0][FS_W-1:0]   fsel_q;
    logic [NPINS-1:0]             latch_q;
    logic [NPINS-1:0][PULL_W-1:0] pull_q;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_in   (pad_in),
        .d_sync (level_sync)
    );

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .level_in  (level_sync),
        .bus_rdata (bus_rdata),
        .fsel_q    (fsel_q),
        .latch_q   (latch_q),
        .pull_q    (pull_q)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_mux (
        .fsel    (fsel_q),
        .latch   (latch_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pad_pull = pull_q;
endmodule

// File: rtl/gpio_fsel_ctrl_chk.sv
module gpio_fsel_ctrl_chk
    import gpio_fsel_pkg::*;
#(
    parameter int NPINS = 54
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_valid,
    input logic                       bus_write,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [REG_W-1:0]           bus_wdata,
    input logic [REG_W-1:0]           bus_rdata,
    input logic [NUM_ALT*NPINS-1:0]   alt_out,
    input logic [NUM_ALT*NPINS-1:0]   alt_oe,
    input logic [NPINS-1:0]           pad_out,
    input logic [NPINS-1:0]           pad_oe,
    input logic [PULL_W*NPINS-1:0]    pad_pull,
    input logic [NPINS-1:0][FS_W-1:0] fsel,
    input logic [NPINS-1:0]           latch
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        p_input_idle_r2: assert property (@(posedge clk) disable iff (rst)
            fsel[p] == 3'b000 |-> !pad_oe[p] && !pad_out[p]);

        p_output_latch_r3: assert property (@(posedge clk) disable iff (rst)
            fsel[p] == 3'b001 |-> pad_oe[p] && pad_out[p] == latch[p]);

        p_alt0_route_r4: assert property (@(posedge clk) disable iff (rst)
            fsel[p] == 3'b100 |-> pad_out[p] == alt_out[p] && pad_oe[p] == alt_oe[p]);

        p_alt4_route_r4: assert property (@(posedge clk) disable iff (rst)
            fsel[p] == 3'b011 |-> pad_out[p] == alt_out[4*NPINS + p]
                                  && pad_oe[p] == alt_oe[4*NPINS + p]);

        p_alt5_route_r4: assert property (@(posedge clk) disable iff (rst)
            fsel[p] == 3'b010 |-> pad_out[p] == alt_out[5*NPINS + p]
                                  && pad_oe[p] == alt_oe[5*NPINS + p]);
    end

    p_latch_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_write) |=> $stable(latch));

    if (NPINS >= 32) begin : g_low_bank
        p_set_low_r6: assert property (@(posedge clk) disable iff (rst)
            bus_valid && bus_write && bus_addr == 8'h1C
            |=> latch[31:0] == ($past(latch[31:0]) | $past(bus_wdata)));

        p_clr_low_r7: assert property (@(posedge clk) disable iff (rst)
            bus_valid && bus_write && bus_addr == 8'h28
            |=> latch[31:0] == ($past(latch[31:0]) & ~$past(bus_wdata)));
    end

    if (NPINS >= 16) begin : g_pull0
        p_pull_write_r9: assert property (@(posedge clk) disable iff (rst)
            bus_valid && bus_write && bus_addr == 8'hE4
            |=> pad_pull[31:0] == $past(bus_wdata));
    end

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_write && (bus_addr == 8'h18 || bus_addr == 8'h30 || bus_addr > 8'hF0)
        |=> bus_rdata == '0);
endmodule

bind gpio_fsel_ctrl gpio_fsel_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alt_out   (alt_out),
    .alt_oe    (alt_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pull  (pad_pull),
    .fsel      (fsel_q),
    .latch     (latch_q)
);

// File: tb/gpio_fsel_ctrl_bench.sv
module gpio_fsel_ctrl_bench;
    localparam int NP = 54;
    localparam int NA = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pad_in = '0;
    logic [NA*NP-1:0]  alt_out = '0;
    logic [NA*NP-1:0]  alt_oe = '0;
    logic [NP-1:0]     pad_out;
    logic [NP-1:0]     pad_oe;
    logic [2*NP-1:0]   pad_pull;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [2:0] m_fsel  [NP];
    logic       m_latch [NP];
    logic [1:0] m_pull  [NP];

    always #2 clk = ~clk;

    gpio_fsel_ctrl #(.NPINS(NP)) u_gpio_fsel_ctrl (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull)
    );

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // code -> alternate port, -1 for input/output
    function automatic int alt_of(logic [2:0] c);
        case (c)
            3'b100: return 0;
            3'b101: return 1;
            3'b110: return 2;
            3'b111: return 3;
            3'b011: return 4;
            3'b010: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic void model_write(logic [7:0] a, logic [31:0] d);
        int w = int'(a[7:2]);
        if (a[1:0] != 2'b00) return;
        for (int p = 0; p < NP; p++) begin
            if (w < 6 && p / 10 == w) m_fsel[p] = d[3*(p%10) +: 3];
            if ((w == 7 || w == 8) && p / 32 == w - 7 && d[p%32]) m_latch[p] = 1'b1;
            if ((w == 10 || w == 11) && p / 32 == w - 10 && d[p%32]) m_latch[p] = 1'b0;
            if (w >= 57 && w <= 60 && p / 16 == w - 57) m_pull[p] = d[2*(p%16) +: 2];
        end
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] r = '0;
        int w = int'(a[7:2]);
        if (a[1:0] != 2'b00) return r;
        for (int p = 0; p < NP; p++) begin
            if (w < 6 && p / 10 == w) r[3*(p%10) +: 3] = m_fsel[p];
            if ((w == 13 || w == 14) && p / 32 == w - 13) r[p%32] = pad_in[p];
            if (w >= 57 && w <= 60 && p / 16 == w - 57) r[2*(p%16) +: 2] = m_pull[p];
        end
        return r;
    endfunction

    task automatic check_pads(string tag);
        logic [NP-1:0]   eo, ee;
        logic [2*NP-1:0] ep;
        for (int p = 0; p < NP; p++) begin
            int a = alt_of(m_fsel[p]);
            ep[2*p +: 2] = m_pull[p];
            if (m_fsel[p] == 3'b000) begin eo[p] = 1'b0; ee[p] = 1'b0; end
            else if (m_fsel[p] == 3'b001) begin eo[p] = m_latch[p]; ee[p] = 1'b1; end
            else begin eo[p] = alt_out[a*NP + p]; ee[p] = alt_oe[a*NP + p]; end
        end
        check({tag, " pad_out"}, 128'(pad_out), 128'(eo));
        check({tag, " pad_oe"},  128'(pad_oe),  128'(ee));
        check({tag, " R9 pad_pull"}, 128'(pad_pull), 128'(ep));
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_check(string tag, logic [7:0] a);
        logic [31:0] d;
        rd(a, d);
        check(tag, 128'(d), 128'(model_read(a)));
    endtask

    task automatic randomize_alt();
        for (int i = 0; i < NA*NP; i++) begin
            alt_out[i] = 1'($urandom);
            alt_oe[i]  = 1'($urandom);
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = $urandom(32'd7321);
        for (int p = 0; p < NP; p++) begin m_fsel[p] = '0; m_latch[p] = 0; m_pull[p] = '0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", 128'(bus_rdata), 128'(0));
        check("R1 pad_oe", 128'(pad_oe), 128'(0));
        check("R1 pad_out", 128'(pad_out), 128'(0));
        check("R1 pad_pull", 128'(pad_pull), 128'(0));
        rd_check("R1 fsel word 0", 8'h00);

        // R5 function word layout and unused fields
        wr(8'h00, 32'hFFFF_FFFF);
        rd_check("R5 fsel0 all ones", 8'h00);
        check("R5 fsel0 literal", 128'(model_read(8'h00)), 128'(32'h3FFF_FFFF));
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d);
        check("R5 fsel5 pins above last read zero", 128'(d), 128'(32'h0000_0FFF));
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h0);
        check_pads("R2 all inputs");

        // R6 set, R3 output mode
        wr(8'h00, 32'h0000_0041);          // pins 0 and 2 -> output
        wr(8'h1C, 32'h0000_0005);
        check_pads("R3 R6 set pins 0,2");
        check("R6 pad_out bits", 128'(pad_out[2:0]), 128'(3'b101));
        wr(8'h1C, 32'h0);
        check("R6 zero write no effect", 128'(pad_out[2:0]), 128'(3'b101));
        rd(8'h1C, d);
        check("R6 set word reads zero", 128'(d), 128'(0));

        // R7 clear and ordering
        wr(8'h28, 32'h0000_0001);
        check("R7 clear pin0", 128'(pad_out[2:0]), 128'(3'b100));
        wr(8'h1C, 32'h1); wr(8'h28, 32'h1);
        check("R7 set then clear", 128'(pad_out[0]), 128'(0));
        wr(8'h28, 32'h1); wr(8'h1C, 32'h1);
        check("R7 clear then set", 128'(pad_out[0]), 128'(1));

        // high bank set/clear on pin 53
        wr(8'h14, 32'h0000_0200);          // pin 53 -> output
        wr(8'h20, 32'h0020_0000);
        check("R6 high bank set pin53", 128'(pad_out[53]), 128'(1));
        wr(8'h2C, 32'h0020_0000);
        check("R7 high bank clear pin53", 128'(pad_out[53]), 128'(0));

        // R11 latch retained across modes
        wr(8'h00, 32'h0000_0001);          // pin 2 back to input
        check("R11 input mode hides latch", 128'(pad_oe[2]), 128'(0));
        wr(8'h00, 32'h0000_0041);
        check("R11 latch reappears", 128'(pad_out[2]), 128'(1));

        // R4 every code on pin 5
        for (int a = 0; a < NA; a++) begin
            alt_out[a*NP + 5] = 1'b1;
            alt_oe[a*NP + 5]  = 1'b1;
        end
        for (int c = 2; c < 8; c++) begin
            alt_out = '0; alt_oe = '0;
            alt_out[alt_of(3'(c))*NP + 5] = 1'b1;
            alt_oe[alt_of(3'(c))*NP + 5]  = 1'b1;
            wr(8'h00, 32'(c) << 15);
            check($sformatf("R4 code %0d out", c), 128'(pad_out[5]), 128'(1));
            check($sformatf("R4 code %0d oe", c), 128'(pad_oe[5]), 128'(1));
            check_pads("R4 routing");
        end

        // R8 level synchroniser
        pad_in = {NP{1'b0}};
        repeat (3) @(negedge clk);
        pad_in[3] = 1'b1; pad_in[40] = 1'b1;
        rd(8'h34, d);                      // issued one cycle after change
        check("R8 one cycle old level", 128'(d[3]), 128'(0));
        pad_in = {NP{1'b0}};
        repeat (3) @(negedge clk);
        pad_in[3] = 1'b1; pad_in[40] = 1'b1;
        @(negedge clk);
        rd(8'h34, d);                      // issued two cycles after change
        check("R8 two cycle new level", 128'(d), 128'(32'h8));
        rd_check("R8 high bank level", 8'h38);
        wr(8'h34, 32'hFFFF_FFFF);
        rd_check("R8 write ignored", 8'h34);
        check_pads("R8 write no side effect");

        // R9 pull words
        wr(8'hE4, 32'hE4E4_E4E4);
        check_pads("R9 pull word 0");
        wr(8'hF0, 32'hFFFF_FFFF);
        rd(8'hF0, d);
        check("R9 pull pins above last read zero", 128'(d), 128'(32'h0000_0FFF));
        check("R9 reserved code passes", 128'(pad_pull[107:106]), 128'(2'b11));

        // R10 unmapped, unaligned, hold
        rd(8'h18, d);
        check("R10 unmapped read", 128'(d), 128'(0));
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        check_pads("R10 unmapped write no effect");
        rd_check("R10 fsel intact", 8'h00);
        rd(8'hE4, d);
        repeat (3) @(negedge clk);
        check("R10 rdata holds", 128'(bus_rdata), 128'(d));

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 6);
            logic [31:0] rdat = $urandom;
            case (op)
                0: wr(8'(4 * ($urandom % 6)), rdat);
                1: wr(($urandom % 2) ? 8'h20 : 8'h1C, rdat);
                2: wr(($urandom % 2) ? 8'h2C : 8'h28, rdat);
                3: wr(8'(8'hE4 + 4 * ($urandom % 4)), rdat);
                4: randomize_alt();
                default: rd_check("R5 R9 R10 random read", 8'($urandom));
            endcase
            @(negedge clk);
            check_pads("R2 R3 R4 R11 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule